// File: doc/BRIEF.md
# Per-line GPIO interrupt detector

The block monitors a vector of GPIO pad levels and keeps one sticky interrupt status bit per line. Each pad passes through a two-flop synchronizer. The synchronized level is compared with the level from the previous clock. A per-line enable, a per-line "any change" override and a 2-bit sensitivity field per line decide when a status bit is set. The same enable bit also turns on the line's output driver, which then carries the line's bit of the output data register.

Software configures the block through a write-only port that takes a word address and one data word. Status bits are cleared by writing ones to a clear address. A single interrupt output combines the status bits with a mask. The status vector is also brought out as a port so the surrounding logic can read it.

Top module: `gpio_irq_detect`

## Requirements
- R1: A line whose enable bit (word address 0) is 0 never sets its status bit, whatever its pad does and however it is configured.
- R2: When a line's override bit (word address 2) is 1, any difference between the previous and the current synchronized level sets its status bit, for every value of its sensitivity field.
- R3: Line i's sensitivity field is bits 2i+1 (mode) and 2i (polarity) of a 2*NLINES-bit configuration value. Word address 3 writes its lower half and word address 4 writes its upper half, so line 20's field is bits 9:8 of the word written to address 4.
- R4: With mode 1, the status bit is set only when the level changed and the new level differs from the polarity bit. Polarity 0 therefore detects rising changes and polarity 1 detects falling changes.
- R5: With mode 0, the status bit is set on every clock at which the current level equals the polarity bit.
- R6: pad_oe equals the enable register. pad_out carries the data register (word address 1) on enabled lines and 0 on the other lines.
- R7: Status bits are sticky. Writing 1 to a bit at word address 6 clears that bit. A bit set by detection in the same cycle as its clear stays 1.
- R8: irq is 1 exactly when some status bit and its mask bit (word address 5) are both 1.
- R9: A pad change driven between clock edges becomes visible in status after the third rising clock edge, and not after the second.
- R10: After reset, status, pad_out, pad_oe and irq are all 0, and all configuration registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | NLINES | Raw pad levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | NLINES | Write data |
| pad_out | output | NLINES | Output data to the pads |
| pad_oe | output | NLINES | Output enables to the pads |
| status | output | NLINES | Sticky interrupt status |
| irq | output | 1 | Combined masked interrupt |

## Verification
Detection and clearing can hit the same status bit in the same cycle. With a level-high line held high, detection fires on every clock, so a clear write at any moment collides with it. The bench provokes this case, and the expected result is that the bit still reads 1 a few cycles later. Only after the pad drops does the same clear leave the bit at 0.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pad_in,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [NLINES-1:0] wr_data,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic [NLINES-1:0] status,
  output logic              irq
);
  localparam logic [2:0] A_EN   = 3'd0;
  localparam logic [2:0] A_DATA = 3'd1;
  localparam logic [2:0] A_ANY  = 3'd2;
  localparam logic [2:0] A_CFGL = 3'd3;
  localparam logic [2:0] A_CFGH = 3'd4;
  localparam logic [2:0] A_MASK = 3'd5;
  localparam logic [2:0] A_CLR  = 3'd6;

  logic [NLINES-1:0]   en_q, data_q, any_q, mask_q;
  logic [NLINES-1:0]   cfgl_q, cfgh_q;
  logic [2*NLINES-1:0] cfg;
  logic [NLINES-1:0]   sync1, lvl, prev;
  logic [NLINES-1:0]   hit, clr_vec, chg;

  assign cfg     = {cfgh_q, cfgl_q};
  assign chg     = lvl ^ prev;
  assign clr_vec = (wr_en && wr_addr == A_CLR) ? wr_data : '0;

  always_comb begin
    for (int i = 0; i < NLINES; i++) begin
      if (any_q[i])          hit[i] = chg[i];
      else if (cfg[2*i+1])   hit[i] = chg[i] & (lvl[i] != cfg[2*i]);
      else                   hit[i] = (lvl[i] == cfg[2*i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; data_q <= '0; any_q <= '0; mask_q <= '0;
      cfgl_q <= '0; cfgh_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_EN:    en_q   <= wr_data;
        A_DATA:  data_q <= wr_data;
        A_ANY:   any_q  <= wr_data;
        A_CFGL:  cfgl_q <= wr_data;
        A_CFGH:  cfgh_q <= wr_data;
        A_MASK:  mask_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0; lvl <= '0; prev <= '0; status <= '0;
    end else begin
      sync1  <= pad_in;
      lvl    <= sync1;
      prev   <= lvl;
      status <= (status & ~clr_vec) | (hit & en_q);
    end
  end

  assign pad_oe  = en_q;
  assign pad_out = data_q & en_q;
  assign irq     = |(status & mask_q);

  a_r1_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~$past(en_q)) == '0);

  a_r2_override_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & $past(any_q) & ~$past(lvl ^ prev)) == '0);

  logic [NLINES-1:0] mode_b;
  always_comb for (int i = 0; i < NLINES; i++) mode_b[i] = cfg[2*i+1];

  a_r4_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & $past(mode_b & ~any_q) & ~$past(lvl ^ prev)) == '0);

  a_r6_data_to_pads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DATA) |=> ((pad_out & pad_oe) == ($past(wr_data) & pad_oe)));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) & ~$past(clr_vec) & ~status) == '0);

  a_r8_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);
endmodule

// File: tb/gpio_irq_detect_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb_top;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] pad_in = '0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] pad_out, pad_oe, status;
  logic irq;
  int tests = 0, fails = 0;

  gpio_irq_detect #(.NLINES(N)) dut_i (.clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pad_out(pad_out),
    .pad_oe(pad_oe), .status(status), .irq(irq));

  always #2.5 clk = ~clk;

  typedef struct { string tag; logic [N-1:0] st; logic ir; } exp_t;
  exp_t q[$];

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        check({it.tag, " status"}, status, it.st);
        check({it.tag, " irq"}, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, it.ir});
      end
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic expect_st(string tag, logic [N-1:0] st, logic ir);
    exp_t it;
    it.tag = tag; it.st = st; it.ir = ir;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pad(int line, logic v);
    @(negedge clk); pad_in[line] = v;
  endtask

  initial begin : watchdog
    #900000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : driver
    idle(3); rst_n = 1; idle(2);
    // R10 reset state
    check("R10 pad_out", pad_out, '0);
    check("R10 pad_oe", pad_oe, '0);
    expect_st("R10 reset", '0, 0);
    // R1: disabled lines, level-low config everywhere, line0 toggles
    pad(0, 1); idle(3); pad(0, 0); idle(3); pad(0, 1); idle(5);
    expect_st("R1 disabled", '0, 0);
    wr(3'd3, 32'hAAAAAAAA); wr(3'd4, 32'hAAAAAAAA); wr(3'd0, '1);
    idle(5); wr(3'd6, '1); idle(3);
    expect_st("R4 setup quiet", '0, 0);
    // R9 latency, line1 rising
    pad(1, 1);
    @(posedge clk); @(posedge clk); #1;
    check("R9 after two edges", status, '0);
    @(posedge clk); #1;
    check("R9 after three edges", status, 32'h2);
    idle(3);
    pad(1, 0); idle(5);
    expect_st("R7 sticky after fall", 32'h2, 0);
    wr(3'd6, 32'h1); idle(2);
    expect_st("R7 other bit clear", 32'h2, 0);
    wr(3'd6, 32'h2); idle(2);
    expect_st("R7 cleared", '0, 0);
    // R4 falling on line2
    wr(3'd3, 32'hAAAAAABA);
    pad(2, 1); idle(5);
    expect_st("R4 falling ignores rise", '0, 0);
    pad(2, 0); idle(5);
    expect_st("R4 falling detected", 32'h4, 0);
    wr(3'd6, '1); idle(2);
    // R2 override on line3 (rising config)
    wr(3'd2, 32'h8);
    pad(3, 1); idle(5);
    expect_st("R2 override rise", 32'h8, 0);
    wr(3'd6, '1); idle(2);
    pad(3, 0); idle(5);
    expect_st("R2 override fall", 32'h8, 0);
    wr(3'd6, '1); idle(2);
    // R3 upper half: line20 falling via bits 9:8 of high word
    wr(3'd4, 32'hAAAAABAA);
    pad(20, 1); idle(5);
    expect_st("R3 line20 rise ignored", '0, 0);
    pad(20, 0); idle(5);
    expect_st("R3 line20 fall", 32'h0010_0000, 0);
    wr(3'd6, '1); idle(2);
    // R5 level-high on line5, clear collides with detection (R7)
    wr(3'd3, 32'hAAAAA6BA); idle(5);
    expect_st("R5 low level quiet", '0, 0);
    pad(5, 1); idle(5);
    expect_st("R5 level high", 32'h20, 0);
    wr(3'd6, '1); idle(3);
    expect_st("R7 set wins over clear", 32'h20, 0);
    pad(5, 0); idle(5); wr(3'd6, '1); idle(3);
    expect_st("R5 released", '0, 0);
    // R8 mask
    pad(1, 1); idle(5);
    expect_st("R8 masked off", 32'h2, 0);
    wr(3'd5, 32'h2); idle(1);
    expect_st("R8 unmasked", 32'h2, 1);
    wr(3'd5, 32'h4); idle(1);
    expect_st("R8 other mask", 32'h2, 0);
    wr(3'd6, '1); idle(2);
    // R6 outputs
    wr(3'd1, 32'h5A); idle(1);
    check("R6 pad_out all enabled", pad_out, 32'h5A);
    check("R6 pad_oe all", pad_oe, '1);
    wr(3'd0, 32'h0F); idle(1);
    check("R6 pad_out partial", pad_out, 32'h0A);
    check("R6 pad_oe partial", pad_oe, 32'h0F);
    // R1 again: line6 now disabled
    pad(6, 1); idle(5);
    expect_st("R1 line6 disabled", '0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule